// File: doc/BRIEF.md
# Hitless Reference Switch Phase Corrector

This block sits ahead of a phase detector in a clock-recovery loop. It chooses one of two reference strobes, sampled on a fast system clock, and passes a virtual reference pulse to the loop. When the reference changes and correction is on, the block measures how many system clocks lie between a rising edge of the new reference and the next rising edge of the loop feedback. It stores that count and delays every later edge of the new reference by it. The virtual reference then keeps the phase that the old reference had, so the loop sees no phase step.

When correction is off at a switch, or when the switch comes as the device returns from a short holdover, no measurement is taken. Instead the stored delay shrinks toward zero in bounded steps, once per slow tick. The output phase therefore moves toward the new reference at a capped rate. A filtered active-low clear input wipes the stored delay, but only after it has been held low long enough.

Top module: `hitless_ref_switch`

## Requirements
- R1: After reset, `vref_pulse` is 0 and `stored_offset` is 0.
- R2: `sel_b` = 0 selects `ref_a` and `sel_b` = 1 selects `ref_b`. Rising edges on the reference that is not selected produce no `vref_pulse`.
- R3: A rising edge of the selected reference is first sampled at system clock edge P0. `vref_pulse` is then high after edge P(2 + `stored_offset`).
- R4: A switch is a change of the synchronized `sel_b`. If at a switch `corr_en_man` or `corr_en_auto` is 1 and `holdover_ret` is 0, the first completed measurement replaces `stored_offset`. A measurement counts system clocks from the edge that samples a rising edge of the new reference to the edge that samples the next rising edge of `fb_in`. The count saturates at 2^CNT_W-1.
- R5: After a corrected switch, each edge of the new reference gives a `vref_pulse` delayed by the measured count, as stated in R3.
- R6: Holding `clr_n` low for at least CLR_MIN_CYC system clocks sets `stored_offset` to 0. A low pulse shorter than that leaves it unchanged.
- R7: At a switch with both enables 0, `stored_offset` falls toward 0. It falls by SLEW_MAX (or less, stopping at 0) on each internal tick, and a tick occurs once every TICK_DIV system clocks. Between ticks it does not change.
- R8: At a switch with `holdover_ret` = 1, no measurement is stored even if correction is enabled. The stored value slews as in R7.
- R9: Each `vref_pulse` lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference strobe A (selected when sel_b = 0) |
| ref_b | input | 1 | Reference strobe B (selected when sel_b = 1) |
| sel_b | input | 1 | Reference select |
| fb_in | input | 1 | Feedback clock from the loop output |
| corr_en_man | input | 1 | Manual correction enable |
| corr_en_auto | input | 1 | Automatic correction request from state control |
| holdover_ret | input | 1 | Marks a switch that returns from a short holdover; suppresses measurement |
| clr_n | input | 1 | Active-low clear of the stored delay, length-filtered |
| vref_pulse | output | 1 | One-clock virtual reference pulse |
| stored_offset | output | CNT_W | Currently stored delay in system clocks |

## Verification
Assertions check these rules on every cycle. The virtual pulse is always one clock wide. The stored value changes only at a clear, at a capture or on a tick. Outside a capture it never rises and never drops by more than the slew limit. A capture loads exactly the completed count. A switch without valid correction leaves nothing armed. Only the bench scenarios can show the rest. They show the end-to-end latency from a pin edge to the virtual pulse and the exact measured count for a given edge spacing. They show that the stored value saturates, that a short clear is rejected, and that the slew keeps its cadence across a whole settle.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  // Saturating increment on a value bounded by maxv.
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned maxv);
    return (cur >= maxv) ? maxv : cur + 1;
  endfunction

  // One slew step toward zero, never crossing it.
  function automatic int unsigned slew_down(input int unsigned cur, input int unsigned step);
    return (cur > step) ? cur - step : 0;
  endfunction
endpackage

// File: rtl/hrs_sync_edge.sv
module hrs_sync_edge #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] chg
);
  logic [W-1:0] s1, s2, s3;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g] <= RST_VAL[g];
        s2[g] <= RST_VAL[g];
        s3[g] <= RST_VAL[g];
      end else begin
        s1[g] <= din[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
    end
    assign lvl[g]  = s2[g];
    assign rise[g] = s2[g] & ~s3[g];
    assign chg[g]  = s2[g] ^ s3[g];
  end
endmodule

// File: rtl/hrs_phase_meter.sv
module hrs_phase_meter
  import hrs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_val
);
  localparam int unsigned CMAX = (1 << CNT_W) - 1;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; busy <= 1'b0; meas_valid <= 1'b0; meas_val <= '0;
    end else if (ref_rise) begin
      cnt <= CNT_W'(1); busy <= 1'b1; meas_valid <= 1'b0;
    end else if (busy && fb_rise) begin
      meas_valid <= 1'b1; meas_val <= cnt; busy <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (busy) cnt <= CNT_W'(sat_inc(int'(cnt), CMAX));
    end
  end

  // R4: a completed count is never zero (counting starts at one)
  a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> meas_val != '0);
endmodule

// File: rtl/hrs_clear_filter.sv
module hrs_clear_filter #(
  parameter int MIN_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_lvl,
  output logic clear_hit
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (clr_lvl)     low_cnt <= '0;
    else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
  end

  assign clear_hit = !clr_lvl && (low_cnt == LIM - 1'b1);

  // R6: a clear only fires while the synchronized input is low
  a_r6_clear_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hit |-> !clr_lvl);
  // R6: a clear fires once per low interval
  a_r6_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hit |=> !clear_hit);
endmodule

// File: rtl/hrs_virtual_ref.sv
module hrs_virtual_ref #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic [CNT_W-1:0] ofs,
  output logic             vref
);
  logic [CNT_W-1:0] dcnt;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0; active <= 1'b0; vref <= 1'b0;
    end else if (ref_rise) begin
      if (ofs == '0) begin
        vref <= 1'b1; active <= 1'b0;
      end else begin
        vref <= 1'b0; active <= 1'b1; dcnt <= ofs;
      end
    end else if (active) begin
      if (dcnt == CNT_W'(1)) begin
        vref <= 1'b1; active <= 1'b0;
      end else begin
        vref <= 1'b0;
      end
      dcnt <= dcnt - 1'b1;
    end else begin
      vref <= 1'b0;
    end
  end

  // R9: virtual reference is a single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vref |=> !vref);
endmodule

// File: rtl/hitless_ref_switch.sv
module hitless_ref_switch
  import hrs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_DIV    = 6250,
  parameter int SLEW_MAX    = 1,
  parameter int CLR_MIN_CYC = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_a,
  input  logic             ref_b,
  input  logic             sel_b,
  input  logic             fb_in,
  input  logic             corr_en_man,
  input  logic             corr_en_auto,
  input  logic             holdover_ret,
  input  logic             clr_n,
  output logic             vref_pulse,
  output logic [CNT_W-1:0] stored_offset
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);

  // bit map of synchronized inputs
  localparam int B_A = 0, B_B = 1, B_FB = 2, B_SEL = 3, B_CLR = 4;

  logic [4:0] s_lvl, s_rise, s_chg;
  hrs_sync_edge #(.W(5), .RST_VAL(5'b10000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({clr_n, sel_b, fb_in, ref_b, ref_a}),
    .lvl(s_lvl), .rise(s_rise), .chg(s_chg)
  );

  // Named internal events
  logic sw_evt, sel_ref_rise, fb_rise, corr_on, clear_hit, tick, cap_take;
  logic meas_valid;
  logic [CNT_W-1:0] meas_val;

  assign sw_evt       = s_chg[B_SEL];
  assign sel_ref_rise = s_lvl[B_SEL] ? s_rise[B_B] : s_rise[B_A];
  assign fb_rise      = s_rise[B_FB];
  assign corr_on      = (corr_en_man || corr_en_auto) && !holdover_ret;

  hrs_phase_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .ref_rise(sel_ref_rise), .fb_rise(fb_rise),
    .meas_valid(meas_valid), .meas_val(meas_val)
  );

  hrs_clear_filter #(.MIN_CYC(CLR_MIN_CYC)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_lvl(s_lvl[B_CLR]), .clear_hit(clear_hit)
  );

  // Slew tick divider
  logic [TW-1:0] tdiv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tdiv <= '0;
    else if (tdiv == TLAST) tdiv <= '0;
    else                    tdiv <= tdiv + 1'b1;
  end
  assign tick = (tdiv == TLAST);

  // Offset storage and its control
  logic [CNT_W-1:0] ofs_q;
  logic armed_q, slewing_q;

  assign cap_take = armed_q && meas_valid && !sw_evt && !clear_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0; armed_q <= 1'b0; slewing_q <= 1'b0;
    end else if (clear_hit) begin
      ofs_q <= '0; armed_q <= 1'b0; slewing_q <= 1'b0;
    end else if (sw_evt) begin
      armed_q   <= corr_on;
      slewing_q <= !corr_on;
    end else if (cap_take) begin
      ofs_q <= meas_val; armed_q <= 1'b0;
    end else if (slewing_q && tick) begin
      ofs_q <= CNT_W'(slew_down(int'(ofs_q), SLEW_MAX));
      if (int'(ofs_q) <= SLEW_MAX) slewing_q <= 1'b0;
    end
  end

  hrs_virtual_ref #(.CNT_W(CNT_W)) u_vref (
    .clk(clk), .rst_n(rst_n), .ref_rise(sel_ref_rise), .ofs(ofs_q), .vref(vref_pulse)
  );

  assign stored_offset = ofs_q;

  // R7: outside capture and clear, the value never rises and steps by at most SLEW_MAX
  a_r7_slew_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_take && !clear_hit) |=>
      (ofs_q <= $past(ofs_q)) && (int'($past(ofs_q)) - int'(ofs_q) <= SLEW_MAX));
  // R7: without a tick, capture or clear, the stored value holds
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_take && !clear_hit && !tick) |=> $stable(ofs_q));
  // R4: a capture loads the completed measurement
  a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> ofs_q == $past(meas_val));
  // R6: a filtered clear empties the store
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hit |=> ofs_q == '0);
  // R8: a switch without valid correction leaves nothing armed
  a_r8_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_evt && !clear_hit && !corr_on) |=> !armed_q);
endmodule

// File: tb/test_hitless_ref_switch.sv
module test_hitless_ref_switch;
  localparam int CNT_W = 8, TICK_DIV = 20, SLEW_MAX = 3, CLR_MIN = 15;

  logic clk = 0, rst_n = 0;
  logic ref_a = 0, ref_b = 0, sel_b = 0, fb_in = 0;
  logic corr_en_man = 0, corr_en_auto = 0, holdover_ret = 0, clr_n = 1;
  logic vref_pulse;
  logic [CNT_W-1:0] stored_offset;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  hitless_ref_switch #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .SLEW_MAX(SLEW_MAX),
                       .CLR_MIN_CYC(CLR_MIN)) i_hitless_ref_switch (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b), .fb_in(fb_in),
    .corr_en_man(corr_en_man), .corr_en_auto(corr_en_auto), .holdover_ret(holdover_ret),
    .clr_n(clr_n), .vref_pulse(vref_pulse), .stored_offset(stored_offset));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ref(bit use_b, logic v);
    if (use_b) ref_b = v; else ref_a = v;
  endtask

  // Raise a reference and check vref_pulse on each following cycle.
  task automatic watch(bit use_b, int n, int exp_at, string req);
    @(negedge clk); set_ref(use_b, 1'b1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(vref_pulse == (i == exp_at), req, int'(vref_pulse), int'(i == exp_at));
    end
    set_ref(use_b, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_switch(logic new_sel, logic man, logic aut, logic hold);
    @(negedge clk);
    corr_en_man = man; corr_en_auto = aut; holdover_ret = hold; sel_b = new_sel;
    repeat (6) @(negedge clk);
  endtask

  task automatic measure(bit use_b, int d);
    @(negedge clk); set_ref(use_b, 1'b1);
    repeat (d) @(negedge clk);
    fb_in = 1;
    repeat (4) @(negedge clk);
    set_ref(use_b, 1'b0); fb_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(vref_pulse == 0, "R1 vref", int'(vref_pulse), 0);
    chk(stored_offset == 0, "R1 offset", int'(stored_offset), 0);
  endtask

  task automatic t_basic;
    watch(1'b0, 8, 2, "R3 zero-offset latency");
    watch(1'b1, 8, -1, "R2 unselected ignored");
  endtask

  task automatic t_capture_manual;
    do_switch(1'b1, 1'b1, 1'b0, 1'b0);
    measure(1'b1, 7);
    chk(stored_offset == 7, "R4 manual capture", int'(stored_offset), 7);
    watch(1'b1, 14, 9, "R5 delayed vref");
    watch(1'b0, 12, -1, "R2 old ref ignored after switch");
  endtask

  task automatic t_capture_auto;
    do_switch(1'b0, 1'b0, 1'b1, 1'b0);
    measure(1'b0, 12);
    chk(stored_offset == 12, "R4 auto capture", int'(stored_offset), 12);
  endtask

  task automatic t_saturate;
    do_switch(1'b1, 1'b1, 1'b0, 1'b0);
    measure(1'b1, 300);
    chk(stored_offset == 255, "R4 saturation", int'(stored_offset), 255);
  endtask

  task automatic t_clear;
    @(negedge clk); clr_n = 0;
    repeat (CLR_MIN - 5) @(negedge clk);
    clr_n = 1;
    repeat (8) @(negedge clk);
    chk(stored_offset == 255, "R6 short clear ignored", int'(stored_offset), 255);
    clr_n = 0;
    repeat (CLR_MIN + 5) @(negedge clk);
    clr_n = 1;
    repeat (4) @(negedge clk);
    chk(stored_offset == 0, "R6 long clear", int'(stored_offset), 0);
  endtask

  task automatic t_holdover;
    do_switch(1'b0, 1'b1, 1'b0, 1'b0);
    measure(1'b0, 10);
    chk(stored_offset == 10, "R8 setup capture", int'(stored_offset), 10);
    do_switch(1'b1, 1'b1, 1'b0, 1'b1);
    measure(1'b1, 9);
    chk(stored_offset != 9 && stored_offset <= 10, "R8 no measurement stored",
        int'(stored_offset), 10);
    repeat (100) @(negedge clk);
    chk(stored_offset == 0, "R8 slewed to zero", int'(stored_offset), 0);
    holdover_ret = 0;
  endtask

  task automatic t_slew;
    int prev, changes, bad_delta, bad_gap, gap;
    do_switch(1'b0, 1'b1, 1'b0, 1'b0);
    measure(1'b0, 30);
    chk(stored_offset == 30, "R7 setup capture", int'(stored_offset), 30);
    prev = int'(stored_offset); changes = 0; bad_delta = 0; bad_gap = 0; gap = 0;
    @(negedge clk);
    corr_en_man = 0; corr_en_auto = 0; sel_b = 1;
    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      gap++;
      if (int'(stored_offset) != prev) begin
        if (prev - int'(stored_offset) != SLEW_MAX) bad_delta++;
        if (changes > 0 && gap != TICK_DIV) bad_gap++;
        changes++; gap = 0; prev = int'(stored_offset);
      end
    end
    chk(changes == 10, "R7 step count", changes, 10);
    chk(bad_delta == 0, "R7 step size", bad_delta, 0);
    chk(bad_gap == 0, "R7 tick spacing", bad_gap, 0);
    chk(stored_offset == 0, "R7 final value", int'(stored_offset), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_basic;
    t_capture_manual;
    t_capture_auto;
    t_saturate;
    t_clear;
    t_holdover;
    t_slew;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule